// File: doc/BRIEF.md
# Incrementing Pattern Memory Tester

This block is a self-test engine for a word-wide memory reached through a request/acknowledge port. A start pulse launches a run over a fixed number of consecutive word locations beginning one word above a supplied base address. At every location the engine writes a value taken from a running counter, then reads the same location straight back and compares the result with what it wrote before moving to the next word.

A run ends in one of two ways. After the last location compares cleanly, the engine reports done with pass set. On the first mismatch it halts for good with pass clear, and keeps the failing address, the expected value and the value read back on status outputs until reset. Start pulses that arrive mid-run or after a failure are ignored. A passed run may be restarted with a new start pulse.

Top module: `pattern_walk_tester`

## Requirements
- R1: After reset, busy, done, pass and mem_req are all low and the fail status outputs read zero.
- R2: A start pulse while idle or after a passing run begins a new run; busy is high from the next cycle until the run ends; start while busy has no effect on the transfer sequence.
- R3: The first location tested is base_addr + 1, and each following location is one word higher, wrapping modulo 2^ADDR_W.
- R4: The value written at the k-th location (k counting from 1) is the low DATA_W bits of k.
- R5: Each write handshake is followed directly by a read request to the same address, and that read completes before the next write begins.
- R6: A request holds mem_addr, mem_we and mem_wdata steady until the cycle in which mem_ack is high; each cycle with mem_req and mem_ack both high completes exactly one transfer.
- R7: After NUM_WORDS clean comparisons, done and pass are high, busy is low and no further requests are issued.
- R8: On the first read whose data differs from the written value, done goes high with pass low, and fail_addr, fail_expect and fail_actual hold that address, the written value and the value read.
- R9: After a failure the engine issues no requests and ignores start until reset; done stays high and pass stays low.
- R10: done and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a run |
| base_addr | input | ADDR_W | Word address one below the first tested location |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (pass or fail) |
| pass | output | 1 | Finished run had no mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_expect | output | DATA_W | Value written at the failing address |
| fail_actual | output | DATA_W | Value read at the failing address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory acknowledge; completes the pending request |
| mem_rdata | input | DATA_W | Read data, valid while mem_ack is high on a read |

## Verification
The bench builds the block with ADDR_W=12, DATA_W=16 and the full NUM_WORDS=1024, so a complete run fits in a few thousand cycles while the 12-bit address space lets a base near its top carry the walk across the wrap to zero. The small address width also lets the bench memory model cover every address, so a single corrupted location can be injected at a chosen step to reach the halt path and the captured status.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_PASS  = 3'd3,
    ST_FAIL  = 3'd4
  } pwt_state_e;
endpackage

// File: rtl/pwt_walker.sv
module pwt_walker #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int NUM_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] pattern,
  output logic              last
);
  localparam int CNT_W = $clog2(NUM_WORDS + 1);

  logic [CNT_W-1:0] count_q;
  logic [ADDR_W-1:0] addr_q;

  // pointer is advanced once before the first write
  function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // written value is the counter truncated or extended to the data width
  function automatic logic [DATA_W-1:0] pattern_of(input logic [CNT_W-1:0] c);
    return DATA_W'(c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      addr_q  <= '0;
    end else if (load) begin
      count_q <= CNT_W'(1);
      addr_q  <= next_word(base);
    end else if (step) begin
      count_q <= count_q + CNT_W'(1);
      addr_q  <= next_word(addr_q);
    end
  end

  assign addr    = addr_q;
  assign pattern = pattern_of(count_q);
  assign last    = (count_q == CNT_W'(NUM_WORDS));
endmodule

// File: rtl/pwt_fsm.sv
module pwt_fsm
  import pwt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mem_ack,
  input  logic       mismatch,
  input  logic       last,
  output pwt_state_e state,
  output logic       load,
  output logic       step,
  output logic       wr_hs,
  output logic       rd_hs
);
  pwt_state_e state_q, state_d;

  assign wr_hs = (state_q == ST_WRITE) && mem_ack;
  assign rd_hs = (state_q == ST_READ) && mem_ack;
  assign load  = start && ((state_q == ST_IDLE) || (state_q == ST_PASS));
  assign step  = rd_hs && !mismatch && !last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_PASS: if (load) state_d = ST_WRITE;
      ST_WRITE:         if (wr_hs) state_d = ST_READ;
      ST_READ: begin
        if (rd_hs) begin
          if (mismatch)  state_d = ST_FAIL;
          else if (last) state_d = ST_PASS;
          else           state_d = ST_WRITE;
        end
      end
      ST_FAIL:          state_d = ST_FAIL;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pwt_fail_latch.sv
module pwt_fail_latch #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] expect_val,
  input  logic [DATA_W-1:0] actual_val,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_expect,
  output logic [DATA_W-1:0] fail_actual
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_addr   <= '0;
      fail_expect <= '0;
      fail_actual <= '0;
    end else if (capture) begin
      fail_addr   <= addr;
      fail_expect <= expect_val;
      fail_actual <= actual_val;
    end
  end
endmodule

// File: rtl/pattern_walk_tester.sv
module pattern_walk_tester
  import pwt_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int NUM_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_expect,
  output logic [DATA_W-1:0] fail_actual,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  pwt_state_e        state;
  logic              load, step, wr_hs, rd_hs, last, mismatch;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_pattern;

  pwt_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_walker (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .base(base_addr),
    .addr(cur_addr), .pattern(cur_pattern), .last(last)
  );

  pwt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_ack(mem_ack),
    .mismatch(mismatch), .last(last), .state(state), .load(load),
    .step(step), .wr_hs(wr_hs), .rd_hs(rd_hs)
  );

  // compare happens in the read acknowledge cycle
  assign mismatch = rd_hs && (mem_rdata != cur_pattern);

  pwt_fail_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fail (
    .clk(clk), .rst_n(rst_n), .capture(mismatch), .addr(cur_addr),
    .expect_val(cur_pattern), .actual_val(mem_rdata),
    .fail_addr(fail_addr), .fail_expect(fail_expect), .fail_actual(fail_actual)
  );

  assign busy      = (state == ST_WRITE) || (state == ST_READ);
  assign done      = (state == ST_PASS) || (state == ST_FAIL);
  assign pass      = (state == ST_PASS);
  assign mem_req   = busy;
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = cur_addr;
  assign mem_wdata = cur_pattern;
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_read_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we |=> mem_req && !mem_we && (mem_addr == $past(mem_addr)));

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !pass |=> done && !pass && !mem_req);

  assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind pattern_walk_tester pwt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pattern_walk_tester_bench.sv
module pattern_walk_tester_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NW = 1024;
  localparam int LAT = 1;

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } xfer_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic busy, done, pass, mem_req, mem_we, mem_ack;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [DW-1:0] fail_expect, fail_actual, mem_wdata, mem_rdata;

  int errors = 0, checks = 0, cycles = 0;
  xfer_t exp_q[$];

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          bad_en = 0;
  logic [AW-1:0] bad_addr = '0;
  int            wait_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_walk_tester #(.ADDR_W(AW), .DATA_W(DW), .NUM_WORDS(NW)) u_pattern_walk_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr),
    .fail_expect(fail_expect), .fail_actual(fail_actual),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: one wait cycle, then a one-cycle acknowledge
  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    mem_ack = 0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 0;
    end else if (mem_req) begin
      if (wait_cnt < LAT) wait_cnt <= wait_cnt + 1;
      else begin
        wait_cnt <= 0;
        mem_ack  <= 1;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else mem_rdata <= mem[mem_addr] ^ ((bad_en && mem_addr == bad_addr) ? DW'(1) : DW'(0));
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver: expected write/read pairs for locations 1..n of a run (R3, R4, R5)
  task automatic push_run(input logic [AW-1:0] base, input int n);
    for (int k = 1; k <= n; k++) begin
      xfer_t w, r;
      w.we = 1; w.addr = base + AW'(k); w.data = DW'(k);
      r.we = 0; r.addr = w.addr;        r.data = w.data;
      exp_q.push_back(w);
      exp_q.push_back(r);
    end
  endtask

  // monitor: every completed transfer is popped and compared (R6)
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_q.size() == 0) begin
        check(0, "R7/R9 unexpected transfer", {20'd0, mem_addr}, 32'd0);
      end else begin
        xfer_t e;
        e = exp_q.pop_front();
        check(mem_we == e.we, "R5 transfer kind", {31'd0, mem_we}, {31'd0, e.we});
        check(mem_addr == e.addr, "R3 address", {20'd0, mem_addr}, {20'd0, e.addr});
        if (e.we) check(mem_wdata == e.data, "R4 write data", {16'd0, mem_wdata}, {16'd0, e.data});
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_up();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !pass && !mem_req, "R1 reset outputs", {28'd0, busy, done, pass, mem_req}, 32'd0);
    check(fail_addr == 0 && fail_expect == 0, "R1 fail status", {20'd0, fail_addr}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // run 1: plain pass, with a stray start mid-run (R2)
    base_addr = 12'h100;
    push_run(base_addr, NW);
    pulse_start();
    check(busy, "R2 busy after start", {31'd0, busy}, 32'd1);
    repeat (40) @(negedge clk);
    pulse_start();
    wait_done();
    check(pass && !busy, "R7 pass after full run", {30'd0, pass, busy}, 32'd2);
    check(exp_q.size() == 0, "R7 all transfers seen", exp_q.size(), 32'd0);
    repeat (20) @(negedge clk);
    check(done && pass && !mem_req, "R7 quiet after pass", {29'd0, done, pass, mem_req}, 32'd6);

    // run 2: restart after pass, walk wraps past the top of the address space (R3)
    base_addr = 12'hF80;
    push_run(base_addr, NW);
    pulse_start();
    check(!done && busy, "R10 done clears on restart", {30'd0, done, busy}, 32'd1);
    wait_done();
    check(pass, "R3 wrap run passes", {31'd0, pass}, 32'd1);
    check(exp_q.size() == 0, "R3 wrap transfers seen", exp_q.size(), 32'd0);

    // run 3: corrupted read at the fifth location (R8)
    base_addr = 12'h040;
    bad_en = 1;
    bad_addr = 12'h045;
    push_run(base_addr, 5);
    pulse_start();
    wait_done();
    check(!pass, "R8 fail reported", {31'd0, pass}, 32'd0);
    check(fail_addr == 12'h045, "R8 fail address", {20'd0, fail_addr}, 32'h45);
    check(fail_expect == 16'd5, "R8 expected value", {16'd0, fail_expect}, 32'd5);
    check(fail_actual == 16'd4, "R8 read value", {16'd0, fail_actual}, 32'd4);
    check(exp_q.size() == 0, "R8 stopped at failure", exp_q.size(), 32'd0);

    // R9: start after failure is ignored
    pulse_start();
    repeat (30) @(negedge clk);
    check(done && !pass && !busy && !mem_req, "R9 halted after fail",
          {28'd0, done, pass, busy, mem_req}, 32'd8);
    check(fail_addr == 12'h045, "R9 status held", {20'd0, fail_addr}, 32'h45);

    // reset releases the halt (R1)
    rst_n = 0;
    @(negedge clk);
    check(!done && !busy && fail_addr == 0, "R1 reset after fail", {30'd0, done, busy}, 32'd0);
    rst_n = 1;
    bad_en = 0;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule